// File: doc/BRIEF.md
# Packed Unsigned 64-bit to Half-Precision Converter

This block turns a vector of unsigned 64-bit integers into IEEE 754 half-precision values in a single registered operation. A 512-bit source carries up to eight integer lanes. A vector-length select picks how many lanes are live: 2, 4 or 8. Each live lane yields one 16-bit result packed into a 128-bit output. Result bits above the live lanes read as zero.

Each lane can be gated by a per-lane mask. A gated-off lane is either cleared or keeps the matching field of the previous destination, which is supplied on its own input. For a memory-style source, lane 0 can be replicated to every lane. For a register source at full width, the same flag instead selects a static rounding mode given with the operation. Otherwise the rounding mode comes from a global control input.

The block reports overflow and inexact status for the lanes it converted, and it raises an overflow exception request when overflow is not masked. Results appear on the clock edge after `in_valid`, and they hold until the next accepted operation.

Top module: `u64_half_vec`

## Requirements
- R1: `vlen_sel` picks the live lane count: 00 gives 2 lanes, 01 gives 4 lanes, and 10 or 11 gives 8 lanes. Source lane j is `src[64j+63:64j]`, and result lane j is `result[16j+15:16j]`.
- R2: A converted lane with value zero gives 0x0000. A nonzero value gives sign 0, biased exponent (position of the leading one) + 15, and the next 10 bits as the fraction. Values below 2048 convert exactly and raise no flag.
- R3: Rounding mode code 00 rounds to nearest with ties to even, 01 rounds toward minus infinity, 10 rounds toward plus infinity, and 11 rounds toward zero. A round-up that carries out of the significand increments the exponent.
- R4: A lane whose rounded magnitude exceeds 65504 overflows. Under modes 00 and 10 the result is 0x7C00. Under modes 01 and 11 the result is 0x7BFF.
- R5: A live lane is converted when `mask_en` is 0 or its bit of `mask` is 1. With `mask_en`=1, `zero_mode`=0 and the mask bit clear, the lane outputs the matching 16 bits of `dst_old`.
- R6: With `mask_en`=1, `zero_mode`=1 and the mask bit clear, the live lane outputs 0x0000.
- R7: When `src_is_mem`=1 and `bcast_rc`=1, every live lane converts source lane 0.
- R8: The rounding mode is `rc_static` only when `src_is_mem`=0, `bcast_rc`=1 and 8 lanes are live. In every other case it is `rc_global`.
- R9: Result bits above 32 times (live lane count)/2, that is above bit 16·lanes−1, are zero.
- R10: `flag_ovf` is set when any converted lane overflows. `flag_inex` is set when any converted lane discarded nonzero bits or overflowed. `ovf_trap` equals `flag_ovf` AND NOT `ovf_mask`. Lanes that are gated off or not live raise no flag.
- R11: `out_valid` goes high for exactly the cycle after each `in_valid` cycle. `result` and the flags update only then, and they hold otherwise. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| src | input | 512 | Eight unsigned 64-bit source lanes |
| dst_old | input | 128 | Previous destination, used when merging |
| mask | input | 8 | Per-lane write enable |
| mask_en | input | 1 | 1 applies `mask`, 0 converts every live lane |
| zero_mode | input | 1 | 1 clears gated lanes, 0 merges them |
| vlen_sel | input | 2 | Vector length: 00=2, 01=4, 1x=8 lanes |
| src_is_mem | input | 1 | Source is memory-style (enables broadcast) |
| bcast_rc | input | 1 | Broadcast (memory source) or static rounding (register source) |
| rc_static | input | 2 | Per-operation rounding mode |
| rc_global | input | 2 | Global rounding mode |
| ovf_mask | input | 1 | 1 suppresses the overflow exception request |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Packed half-precision results |
| flag_ovf | output | 1 | Overflow status |
| flag_inex | output | 1 | Inexact status |
| ovf_trap | output | 1 | Unmasked overflow exception request |

## Verification
On every cycle, the assertions check the valid timing, that results hold between operations, that the upper bits are cleared for short vectors, and that a zeroed lane reads zero. They also check that overflow always brings inexact with it and that the exception request implies both flags. Only the bench scenarios can show the numeric results: the rounding choices at ties, carries and the 65504/65520 boundaries for each mode, merge data, broadcast replication, and which rounding source was chosen.

// File: rtl/u2h_pkg.sv
package u2h_pkg;
    localparam int INT_W  = 64;
    localparam int HALF_W = 16;
    localparam int POS_W  = $clog2(INT_W);

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;
endpackage

// File: rtl/u2h_lead_one.sv
module u2h_lead_one #(
    parameter int W  = 64,
    localparam int PW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [PW-1:0] pos,
    output logic          found
);
    always_comb begin
        pos   = '0;
        found = |vec;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) pos = PW'(i);
        end
    end
endmodule

// File: rtl/u2h_rm_pick.sv
module u2h_rm_pick
    import u2h_pkg::*;
(
    input  logic   src_is_mem,
    input  logic   bcast_rc,
    input  logic   full_width,
    input  rmode_e rc_static,
    input  rmode_e rc_global,
    output rmode_e rm_eff,
    output logic   bcast_eff
);
    always_comb begin
        bcast_eff = src_is_mem && bcast_rc;
        rm_eff    = (!src_is_mem && bcast_rc && full_width) ? rc_static : rc_global;
    end
endmodule

// File: rtl/u2h_lane_cvt.sv
module u2h_lane_cvt
    import u2h_pkg::*;
(
    input  logic [INT_W-1:0]  val,
    input  rmode_e            rm,
    output logic [HALF_W-1:0] half,
    output logic              ovf,
    output logic              inex
);
    logic [POS_W-1:0] lead_pos;
    logic             nonzero;
    logic [INT_W-1:0] norm;
    logic [10:0]      sig;
    logic             guard_b;
    logic             sticky_b;
    logic             bump;
    logic [11:0]      sig_r;
    logic [6:0]       exp_u;

    u2h_lead_one #(.W(INT_W)) u_lead (
        .vec   (val),
        .pos   (lead_pos),
        .found (nonzero)
    );

    always_comb begin
        norm     = val << (~lead_pos);
        sig      = norm[INT_W-1 -: 11];
        guard_b  = norm[INT_W-12];
        sticky_b = |norm[INT_W-13:0];
        unique case (rm)
            RM_NEAR: bump = guard_b && (sticky_b || sig[0]);
            RM_UP:   bump = guard_b || sticky_b;
            default: bump = 1'b0;
        endcase
        sig_r = {1'b0, sig} + 12'(bump);
        exp_u = {1'b0, lead_pos} + 7'(sig_r[11]);
        ovf   = nonzero && (exp_u > 7'd15);
        inex  = nonzero && (guard_b || sticky_b || ovf);
        if (!nonzero)
            half = '0;
        else if (ovf)
            half = (rm == RM_NEAR || rm == RM_UP) ? 16'h7C00 : 16'h7BFF;
        else
            half = {1'b0, 5'(exp_u + 7'd15), sig_r[9:0]};
    end
endmodule

// File: rtl/u64_half_vec.sv
module u64_half_vec
    import u2h_pkg::*;
#(
    parameter int MAX_LANES = 8,
    localparam int SRC_W = MAX_LANES * INT_W,
    localparam int RES_W = MAX_LANES * HALF_W,
    localparam int CNT_W = $clog2(MAX_LANES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SRC_W-1:0] src,
    input  logic [RES_W-1:0] dst_old,
    input  logic [MAX_LANES-1:0] mask,
    input  logic             mask_en,
    input  logic             zero_mode,
    input  logic [1:0]       vlen_sel,
    input  logic             src_is_mem,
    input  logic             bcast_rc,
    input  logic [1:0]       rc_static,
    input  logic [1:0]       rc_global,
    input  logic             ovf_mask,
    output logic             out_valid,
    output logic [RES_W-1:0] result,
    output logic             flag_ovf,
    output logic             flag_inex,
    output logic             ovf_trap
);
    typedef struct packed {
        logic             vld;
        logic [RES_W-1:0] res;
        logic             ovf;
        logic             inex;
        logic             trap;
    } state_t;

    state_t st_d, st_q;

    rmode_e rm_eff;
    logic   bcast_eff;
    logic [CNT_W-1:0] live_cnt;
    logic [INT_W-1:0]  lane_in   [MAX_LANES];
    logic [HALF_W-1:0] lane_half [MAX_LANES];
    logic [MAX_LANES-1:0] lane_ovf, lane_inex;

    u2h_rm_pick u_pick (
        .src_is_mem (src_is_mem),
        .bcast_rc   (bcast_rc),
        .full_width (vlen_sel[1]),
        .rc_static  (rmode_e'(rc_static)),
        .rc_global  (rmode_e'(rc_global)),
        .rm_eff     (rm_eff),
        .bcast_eff  (bcast_eff)
    );

    for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
        assign lane_in[j] = bcast_eff ? src[INT_W-1:0] : src[j*INT_W +: INT_W];
        u2h_lane_cvt u_cvt (
            .val  (lane_in[j]),
            .rm   (rm_eff),
            .half (lane_half[j]),
            .ovf  (lane_ovf[j]),
            .inex (lane_inex[j])
        );
    end

    always_comb begin
        unique case (vlen_sel)
            2'b00:   live_cnt = CNT_W'(2);
            2'b01:   live_cnt = CNT_W'(4);
            default: live_cnt = CNT_W'(MAX_LANES);
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res  = '0;
            st_d.ovf  = 1'b0;
            st_d.inex = 1'b0;
            for (int j = 0; j < MAX_LANES; j++) begin
                if (CNT_W'(j) < live_cnt) begin
                    if (!mask_en || mask[j]) begin
                        st_d.res[j*HALF_W +: HALF_W] = lane_half[j];
                        st_d.ovf  = st_d.ovf  | lane_ovf[j];
                        st_d.inex = st_d.inex | lane_inex[j];
                    end else if (!zero_mode) begin
                        st_d.res[j*HALF_W +: HALF_W] = dst_old[j*HALF_W +: HALF_W];
                    end
                end
            end
            st_d.trap = st_d.ovf && !ovf_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign flag_ovf  = st_q.ovf;
    assign flag_inex = st_q.inex;
    assign ovf_trap  = st_q.trap;

    p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(flag_ovf) && $stable(flag_inex));
    p_upper_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vlen_sel == 2'b00) |=> result[RES_W-1:32] == '0);
    p_upper_clear4_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vlen_sel == 2'b01) |=> result[RES_W-1:64] == '0);
    p_zeroed_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en && zero_mode && !mask[0]) |=> result[HALF_W-1:0] == '0);
    p_ovf_inex_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_ovf |-> flag_inex);
    p_trap_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> (flag_ovf && flag_inex));
endmodule

// File: tb/u64_half_vec_bench.sv
module u64_half_vec_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [511:0] src = '0;
    logic [127:0] dst_old = '0;
    logic [7:0]   mask = '0;
    logic         mask_en = 1'b0, zero_mode = 1'b0;
    logic [1:0]   vlen_sel = 2'b10;
    logic         src_is_mem = 1'b0, bcast_rc = 1'b0;
    logic [1:0]   rc_static = '0, rc_global = '0;
    logic         ovf_mask = 1'b0;
    logic         out_valid;
    logic [127:0] result;
    logic         flag_ovf, flag_inex, ovf_trap;

    int n_tests = 0;
    int n_fail  = 0;
    bit done = 0;

    logic [127:0] exp_res;
    logic         exp_ovf, exp_inex, exp_trap;

    always #2 clk = ~clk;

    u64_half_vec u_u64_half_vec (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .dst_old(dst_old),
        .mask(mask), .mask_en(mask_en), .zero_mode(zero_mode), .vlen_sel(vlen_sel),
        .src_is_mem(src_is_mem), .bcast_rc(bcast_rc), .rc_static(rc_static),
        .rc_global(rc_global), .ovf_mask(ovf_mask), .out_valid(out_valid),
        .result(result), .flag_ovf(flag_ovf), .flag_inex(flag_inex), .ovf_trap(ovf_trap)
    );

    // Behavioural reference: remainder comparison on the dropped bits.
    task automatic ref_cvt(input logic [63:0] x, input logic [1:0] rm,
                           output logic [15:0] h, output logic ovf, output logic inex);
        int p = -1;
        int sh;
        int e;
        logic [63:0] q, rem, halfw;
        logic up;
        ovf = 0; inex = 0; h = 16'h0;
        for (int i = 0; i < 64; i++) if (x[i]) p = i;
        if (p < 0) return;
        if (p <= 10) begin
            q = x << (10 - p);
            h = {1'b0, 5'(p + 15), q[9:0]};
            return;
        end
        sh    = p - 10;
        q     = x >> sh;
        rem   = x & ((64'd1 << sh) - 64'd1);
        halfw = 64'd1 << (sh - 1);
        inex  = (rem != 0);
        case (rm)
            2'b00:   up = (rem > halfw) || (rem == halfw && q[0]);
            2'b10:   up = (rem != 0);
            default: up = 1'b0;
        endcase
        q = q + 64'(up);
        e = p;
        if (q == 64'd2048) begin q = 64'd1024; e = e + 1; end
        if (e > 15) begin
            ovf = 1; inex = 1;
            h = (rm == 2'b00 || rm == 2'b10) ? 16'h7C00 : 16'h7BFF;
        end else begin
            h = {1'b0, 5'(e + 15), q[9:0]};
        end
    endtask

    task automatic model;
        int nl;
        logic [1:0] rm;
        logic [15:0] h;
        logic o, ix;
        nl = (vlen_sel == 2'b00) ? 2 : (vlen_sel == 2'b01) ? 4 : 8;
        rm = (!src_is_mem && bcast_rc && nl == 8) ? rc_static : rc_global;
        exp_res = '0; exp_ovf = 0; exp_inex = 0;
        for (int j = 0; j < nl; j++) begin
            if (!mask_en || mask[j]) begin
                ref_cvt((src_is_mem && bcast_rc) ? src[63:0] : src[j*64 +: 64], rm, h, o, ix);
                exp_res[j*16 +: 16] = h;
                exp_ovf  = exp_ovf | o;
                exp_inex = exp_inex | ix;
            end else if (!zero_mode) begin
                exp_res[j*16 +: 16] = dst_old[j*16 +: 16];
            end
        end
        exp_trap = exp_ovf && !ovf_mask;
    endtask

    task automatic compare(input string tag, input logic vld_exp);
        n_tests++;
        if (out_valid !== vld_exp || result !== exp_res || flag_ovf !== exp_ovf ||
            flag_inex !== exp_inex || ovf_trap !== exp_trap) begin
            n_fail++;
            $display("FAIL %s: got v=%b res=%h o=%b i=%b t=%b, expected v=%b res=%h o=%b i=%b t=%b",
                     tag, out_valid, result, flag_ovf, flag_inex, ovf_trap,
                     vld_exp, exp_res, exp_ovf, exp_inex, exp_trap);
        end
    endtask

    // Drives one operation at a falling edge and checks it one edge later.
    task automatic fire(input string tag);
        in_valid = 1'b1;
        model();
        @(negedge clk);
        in_valid = 1'b0;
        compare(tag, 1'b1);
    endtask

    task automatic set_lanes(input logic [63:0] a0, a1, a2, a3, a4, a5, a6, a7);
        src = {a7, a6, a5, a4, a3, a2, a1, a0};
    endtask

    task automatic defaults;
        mask_en = 0; zero_mode = 0; vlen_sel = 2'b10; src_is_mem = 0; bcast_rc = 0;
        rc_static = 2'b00; rc_global = 2'b00; ovf_mask = 0; mask = 8'h00;
        dst_old = {8{16'hBEEF}};
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        defaults();
        repeat (3) @(negedge clk);
        exp_res = '0; exp_ovf = 0; exp_inex = 0; exp_trap = 0;
        compare("R11 reset state", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: exact small values and zero, full width
        set_lanes(64'd0, 64'd1, 64'd2, 64'd1023, 64'd2047, 64'd1000, 64'd5, 64'd1536);
        fire("R2 exact values");

        // R3: rounding at ties and carries, every mode
        set_lanes(64'd2049, 64'd2051, 64'd2050, 64'd4095, 64'd4097, 64'h8000_0000_0000_0001,
                  64'd12345678, 64'd2053);
        for (int m = 0; m < 4; m++) begin
            rc_global = 2'(m);
            fire("R3 rounding modes");
        end

        // R4: overflow boundaries, every mode
        set_lanes(64'd65504, 64'd65505, 64'd65519, 64'd65520, 64'd65536,
                  64'hFFFF_FFFF_FFFF_FFFF, 64'd65535, 64'd70000);
        for (int m = 0; m < 4; m++) begin
            rc_global = 2'(m);
            fire("R4 overflow per mode");
        end
        rc_global = 2'b00;

        // R5: merge masking
        set_lanes(64'd1, 64'd2, 64'd3, 64'd4, 64'd5, 64'd6, 64'd7, 64'd8);
        dst_old = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
        mask_en = 1; mask = 8'hA5; zero_mode = 0;
        fire("R5 merge mask");
        mask_en = 0;
        fire("R5 mask disabled");

        // R6: zeroing masking
        mask_en = 1; mask = 8'h3C; zero_mode = 1;
        fire("R6 zero mask");

        // R10: overflow in a gated lane raises nothing; masked overflow
        set_lanes(64'd70000, 64'd3, 64'd3, 64'd3, 64'd3, 64'd3, 64'd3, 64'd3);
        mask = 8'hFE;
        fire("R10 gated lane flags");
        mask_en = 0; ovf_mask = 1;
        fire("R10 masked overflow");
        ovf_mask = 0;
        fire("R10 unmasked overflow");

        // R7: broadcast from memory source
        defaults();
        set_lanes(64'd2051, 64'd9, 64'd9, 64'd9, 64'd9, 64'd9, 64'd9, 64'd9);
        src_is_mem = 1; bcast_rc = 1; rc_static = 2'b11; rc_global = 2'b10;
        fire("R7 broadcast lane 0");
        vlen_sel = 2'b01;
        fire("R7 broadcast four lanes");

        // R8: static rounding only for register source at full width
        defaults();
        set_lanes(64'd2049, 64'd4097, 64'd65519, 64'd2051, 64'd1, 64'd2, 64'd3, 64'd4);
        bcast_rc = 1; rc_static = 2'b10; rc_global = 2'b11;
        fire("R8 static rounding full width");
        vlen_sel = 2'b01;
        fire("R8 global rounding at 256");
        vlen_sel = 2'b11;
        fire("R8 code 11 full width");

        // R1 / R9: short vectors clear upper bits
        defaults();
        dst_old = '1;
        set_lanes(64'd7, 64'd8, 64'd9, 64'd10, 64'd11, 64'd12, 64'd13, 64'd14);
        vlen_sel = 2'b00;
        fire("R1 R9 two lanes");
        vlen_sel = 2'b01; mask_en = 1; mask = 8'hF0;
        fire("R1 R9 four lanes merge");

        // R11: hold while idle
        @(negedge clk);
        compare("R11 hold when idle", 1'b0);
        @(negedge clk);
        compare("R11 hold second idle", 1'b0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule